// File: doc/BRIEF.md
# Eight-Bit Shift and Rotate Unit

This unit moves an eight-bit word by at most one bit position in a single combinational step. A three-bit operation code picks one of several behaviours: pass the word through unchanged, shift it one place toward the most significant end, shift it one place toward the least significant end, or rotate it one place in either direction. Two serial fill bits supply the value that enters the vacated position during a logical shift, one bit for each direction.

The unit holds no state and has no clock. It is meant to sit in a datapath between registers, and its result is valid in the same cycle as its inputs. One code pair in the operation encoding is reserved. It is defined to pass the word through, so the output is never undefined.

Top module: `shift_rot_unit`

## Requirements
- R1: With `op[2:1]` = 00, `dout` equals `din` for both values of `op[0]`.
- R2: With `op[2:1]` = 01, which is the reserved code, `dout` equals `din` for both values of `op[0]`.
- R3: With `op` = 100, `dout[7:1]` = `din[6:0]` and `dout[0]` = `fill_r`.
- R4: With `op` = 101, `dout[7:1]` = `din[6:0]` and `dout[0]` = `din[7]`.
- R5: With `op` = 110, `dout[6:0]` = `din[7:1]` and `dout[7]` = `fill_l`.
- R6: With `op` = 111, `dout[6:0]` = `din[7:1]` and `dout[7]` = `din[0]`.
- R7: Neither fill input has any effect on `dout` under codes 000, 001, 010, 011, 101 and 111. `fill_l` has no effect under 100, and `fill_r` has no effect under 110.
- R8: `dout` depends only on the present inputs and settles in the same cycle as they change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Data word to move |
| fill_l | input | 1 | Bit that enters the most significant position on a right shift |
| fill_r | input | 1 | Bit that enters the least significant position on a left shift |
| op | input | 3 | Operation code |
| dout | output | 8 | Result word |

## Verification
The bench applies every combination of data word, fill pair and operation code, so the edge bits are covered, including words such as 0x80 and 0x01 where one wrong bit decides the result. A unit that swapped the two fill inputs would fail R3 and R5 whenever the fill bits differ. A unit that shifted where it should rotate would drop the wrapped-around bit and fail R4 and R6. A unit that left the reserved code undriven, or decoded it as a shift, would break R2. Because the fill inputs are toggled under every code, a fill bit that leaks into a rotate or a pass-through result shows up as a miscompare against R7.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         fill_l,
  input  logic         fill_r,
  input  logic [2:0]   op,
  output logic [W-1:0] dout
);

  logic [W-1:0] up_word;
  logic [W-1:0] dn_word;

  assign up_word = {din[W-2:0], op[0] ? din[W-1] : fill_r};
  assign dn_word = {op[0] ? din[0] : fill_l, din[W-1:1]};

  always_comb begin
    unique case (op[2:1])
      2'b10:   dout = up_word;
      2'b11:   dout = dn_word;
      default: dout = din;
    endcase
  end

  always_comb begin
    if (op[2] == 1'b0)
      p_hold_r1: assert (dout == din) else $error("R1/R2 hold broken");
    if (op == 3'b100)
      p_shl_fill_r3: assert (dout[0] == fill_r && dout[W-1:1] == din[W-2:0]) else $error("R3 shl broken");
    if (op == 3'b101)
      p_rol_ones_r4: assert ($countones(dout) == $countones(din) && dout[0] == din[W-1]) else $error("R4 rol broken");
    if (op == 3'b110)
      p_shr_fill_r5: assert (dout[W-1] == fill_l && dout[W-2:0] == din[W-1:1]) else $error("R5 shr broken");
    if (op == 3'b111)
      p_ror_ones_r6: assert ($countones(dout) == $countones(din) && dout[W-1] == din[0]) else $error("R6 ror broken");
  end

endmodule

// File: tb/shift_rot_unit_tb.sv
module shift_rot_unit_tb;
  logic       clk = 1'b0;
  logic [7:0] din;
  logic       fill_l, fill_r;
  logic [2:0] op;
  logic [7:0] dout;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  shift_rot_unit u_dut (.din(din), .fill_l(fill_l), .fill_r(fill_r), .op(op), .dout(dout));

  function automatic int ref_model(int d, int fl, int fr, int o);
    int r;
    case (o)
      4: r = ((d * 2) % 256) + fr;
      5: r = ((d * 2) % 256) + (d / 128);
      6: r = (d / 2) + fl * 128;
      7: r = (d / 2) + (d % 2) * 128;
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string req_of(int o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(int d, int fl, int fr, int o);
    int exp;
    @(negedge clk);
    din = d[7:0]; fill_l = fl[0]; fill_r = fr[0]; op = o[2:0];
    @(posedge clk);
    #1;
    exp = ref_model(d, fl, fr, o);
    n_vec++;
    if (int'(dout) != exp) begin
      n_bad++;
      $display("FAIL %s (R7/R8 same-cycle) op=%0d din=%02h fl=%0d fr=%0d got=%02h exp=%02h",
               req_of(o), o, d, fl, fr, dout, exp[7:0]);
    end
  endtask

  initial begin
    din = 8'h00; fill_l = 1'b0; fill_r = 1'b0; op = 3'b000;
    // R1 at start: pass-through of zero word
    apply(0, 0, 0, 0);
    // edge words first: R3 R4 R5 R6 boundaries
    apply(8'h80, 0, 1, 4);
    apply(8'h80, 1, 0, 5);
    apply(8'h01, 1, 0, 6);
    apply(8'h01, 0, 1, 7);
    // R2 reserved code with fills toggled, R7 fills ignored
    apply(8'hA5, 1, 1, 2);
    apply(8'h5A, 1, 1, 3);
    // exhaustive sweep covering R1..R8
    for (int o = 0; o < 8; o++)
      for (int f = 0; f < 4; f++)
        for (int d = 0; d < 256; d++)
          apply(d, f / 2, f % 2, o);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule